// File: doc/BRIEF.md
# Link Word CRC-6 Framer and Checker

This block protects one parallel link word on its way to and from the line coder. The transmit half takes a data word that has already been scrambled. In CRC mode it computes a 6-bit CRC over the payload and appends it. It then appends one even-parity bit, which the far end uses to find word boundaries. The result is the word that goes on to byte splitting and line coding.

The receive half takes a word of the same format and checks it. It checks parity and, in CRC mode, recomputes the CRC and compares it with the CRC field in the word. It returns the payload with per-word error flags. Every faulty word increments a saturating error counter, and an error pin shows whether that counter is non-zero.

A width input selects a narrow body of 22 bits or a wide body of 30 bits, and a CRC-enable input decides whether six of those bits carry a CRC. Both halves use valid/ready handshakes with one register stage each. Both inputs apply to the word that is accepted in the same cycle.

Top module: `link_crc_guard`

## Requirements
- R1: With `crc_en_i`=1, the transmit word holds the payload at bits [P+6:7], the CRC at bits [6:1] and parity at bit 0, where P is the payload width. All higher bits are 0. The CRC is the remainder of payload·x^6 divided by x^6+x+1, taking payload bits MSB first with the register starting at zero.
- R2: The payload width is 16 (narrow) or 24 (wide) with CRC, and 22 or 30 without CRC. `wide_i`=1 selects wide. Data bits at or above the payload width are ignored.
- R3: Bit 0 of every transmit word is chosen so that the whole word has an even number of ones.
- R4: The receiver recomputes the CRC over the received payload. It sets `rx_crc_err_o` with the word when the result differs from bits [6:1].
- R5: The receiver sets `rx_par_err_o` when bits [B:0] hold an odd number of ones, where B is 22 (narrow) or 30 (wide).
- R6: Each accepted receive word with a CRC or parity error adds exactly one to `err_cnt_o`. The counter holds at 255.
- R7: `clr_err_i` zeroes the counter on the next clock edge and takes priority over a simultaneous increment.
- R8: `err_o` is 1 exactly when `err_cnt_o` is non-zero.
- R9: With `crc_en_i`=0 the receiver never flags a CRC error and returns the whole 22- or 30-bit body [B:1] as data.
- R10: On each side, `*_ready_o` equals `!*_valid_o || *_ready_i`. An output held with valid=1 and ready=0 keeps its data stable.
- R11: After reset both output valids and the counter are 0.
- R12: Receive word bits above bit B are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 = 30-bit body, 0 = 22-bit body |
| crc_en_i | input | 1 | 1 = body carries a 6-bit CRC |
| clr_err_i | input | 1 | Synchronous clear of the error counter |
| tx_valid_i | input | 1 | Transmit data valid |
| tx_ready_o | output | 1 | Transmit input can accept |
| tx_data_i | input | 30 | Scrambled payload, LSB-aligned |
| tx_valid_o | output | 1 | Framed word valid |
| tx_ready_i | input | 1 | Downstream accepts framed word |
| tx_word_o | output | 31 | Framed word |
| rx_valid_i | input | 1 | Received word valid |
| rx_ready_o | output | 1 | Receive input can accept |
| rx_word_i | input | 31 | Received framed word |
| rx_valid_o | output | 1 | Checked payload valid |
| rx_ready_i | input | 1 | Consumer accepts payload |
| rx_data_o | output | 30 | Recovered payload, LSB-aligned |
| rx_crc_err_o | output | 1 | CRC mismatch on this word |
| rx_par_err_o | output | 1 | Parity mismatch on this word |
| err_o | output | 1 | Error counter non-zero |
| err_cnt_o | output | 8 | Saturating error count |

## Verification
The bench sweeps all four width/CRC combinations with pseudo-random and walking payloads. It loops each framed word back into the receiver and flips every single bit of one word per mode. A design with a wrong field offset or a reflected CRC would fail the loopback, and one that checks parity over the wrong span would miss flips at the body edge. Double flips inside the CRC field keep parity intact, so they can only be caught by the CRC compare. Stray upper bits and CRC-field corruption in CRC-off mode must raise nothing. The bench drives more than 255 bad words and then asserts a clear together with a bad word, which exposes a counter that wraps or lets the increment win over the clear.

// File: rtl/link_crc_pkg.sv
package link_crc_pkg;
  localparam int CRC_W = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'h03;  // x^6 + x + 1, x^6 implicit

  typedef struct packed {
    logic wide;
    logic crc_en;
  } link_mode_t;
endpackage

// File: rtl/crc6_calc.sv
module crc6_calc
  import link_crc_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // MSB first, zero seed: leading zeros leave the register at zero,
  // so a zero-extended narrow payload gives the same remainder.
  always_comb begin
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ data_i[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    crc_o = r;
  end
endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
  import link_crc_pkg::*;
#(
  parameter int NARROW_W = 22,
  parameter int WIDE_W   = 30
) (
  input  link_mode_t        mode_i,
  input  logic [WIDE_W-1:0] data_i,
  output logic [WIDE_W:0]   word_o
);
  localparam int PAY_W = WIDE_W - CRC_W;

  logic [WIDE_W-1:0] mask, pay;
  logic [CRC_W-1:0]  crc;
  logic [WIDE_W-1:0] body;

  always_comb begin
    int n;
    if (mode_i.crc_en) n = mode_i.wide ? WIDE_W - CRC_W : NARROW_W - CRC_W;
    else               n = mode_i.wide ? WIDE_W : NARROW_W;
    mask = '0;
    for (int i = 0; i < WIDE_W; i++) if (i < n) mask[i] = 1'b1;
  end

  assign pay = data_i & mask;

  crc6_calc #(.DATA_W(PAY_W)) u_crc (
    .data_i(pay[PAY_W-1:0]),
    .crc_o (crc)
  );

  assign body   = mode_i.crc_en ? {pay[PAY_W-1:0], crc} : pay;
  assign word_o = {body, ^body};
endmodule

// File: rtl/link_rx_checker.sv
module link_rx_checker
  import link_crc_pkg::*;
#(
  parameter int NARROW_W = 22,
  parameter int WIDE_W   = 30
) (
  input  link_mode_t        mode_i,
  input  logic [WIDE_W:0]   word_i,
  output logic [WIDE_W-1:0] data_o,
  output logic              crc_err_o,
  output logic              par_err_o
);
  localparam int PAY_W = WIDE_W - CRC_W;

  logic [WIDE_W:0]   mask, w;
  logic [WIDE_W-1:0] body;
  logic [CRC_W-1:0]  crc_calc;

  always_comb begin
    int top;
    top  = mode_i.wide ? WIDE_W : NARROW_W;
    mask = '0;
    for (int i = 0; i <= WIDE_W; i++) if (i <= top) mask[i] = 1'b1;
  end

  assign w    = word_i & mask;
  assign body = w[WIDE_W:1];

  crc6_calc #(.DATA_W(PAY_W)) u_crc (
    .data_i(body[WIDE_W-1:CRC_W]),
    .crc_o (crc_calc)
  );

  assign par_err_o = ^w;
  assign crc_err_o = mode_i.crc_en && (crc_calc != body[CRC_W-1:0]);
  assign data_o    = mode_i.crc_en ? {{CRC_W{1'b0}}, body[WIDE_W-1:CRC_W]} : body;
endmodule

// File: rtl/link_stage.sv
module link_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign in_ready_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/link_crc_guard.sv
module link_crc_guard
  import link_crc_pkg::*;
#(
  parameter int NARROW_W = 22,
  parameter int WIDE_W   = 30,
  parameter int CNT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              crc_en_i,
  input  logic              clr_err_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [WIDE_W-1:0] tx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [WIDE_W:0]   tx_word_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [WIDE_W:0]   rx_word_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [WIDE_W-1:0] rx_data_o,
  output logic              rx_crc_err_o,
  output logic              rx_par_err_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  localparam int RX_W = WIDE_W + 2;

  link_mode_t        mode;
  logic [WIDE_W:0]   tx_word_d;
  logic [WIDE_W-1:0] rx_data_d;
  logic              rx_crc_d, rx_par_d;
  logic [RX_W-1:0]   rx_q;

  assign mode.wide   = wide_i;
  assign mode.crc_en = crc_en_i;

  link_tx_framer #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_tx (
    .mode_i(mode),
    .data_i(tx_data_i),
    .word_o(tx_word_d)
  );

  link_stage #(.W(WIDE_W + 1)) u_tx_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (tx_valid_i),
    .in_ready_o (tx_ready_o),
    .in_data_i  (tx_word_d),
    .out_valid_o(tx_valid_o),
    .out_ready_i(tx_ready_i),
    .out_data_o (tx_word_o)
  );

  link_rx_checker #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_rx (
    .mode_i   (mode),
    .word_i   (rx_word_i),
    .data_o   (rx_data_d),
    .crc_err_o(rx_crc_d),
    .par_err_o(rx_par_d)
  );

  link_stage #(.W(RX_W)) u_rx_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (rx_valid_i),
    .in_ready_o (rx_ready_o),
    .in_data_i  ({rx_crc_d, rx_par_d, rx_data_d}),
    .out_valid_o(rx_valid_o),
    .out_ready_i(rx_ready_i),
    .out_data_o (rx_q)
  );

  assign rx_crc_err_o = rx_q[RX_W-1];
  assign rx_par_err_o = rx_q[RX_W-2];
  assign rx_data_o    = rx_q[WIDE_W-1:0];

  err_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_err_i),
    .inc_i (rx_valid_i && rx_ready_o && (rx_crc_d || rx_par_d)),
    .cnt_o (err_cnt_o)
  );

  assign err_o = |err_cnt_o;
endmodule

// File: rtl/link_crc_guard_chk.sv
module link_crc_guard_chk #(
  parameter int WIDE_W = 30,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_err_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [WIDE_W:0]   tx_word_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [WIDE_W-1:0] rx_data_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  err_cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  p_tx_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (^tx_word_o) == 1'b0);

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_word_o));

  p_rx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));

  p_cnt_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o == MAX && !clr_err_i |=> err_cnt_o == MAX);

  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_err_i |=> (err_cnt_o == $past(err_cnt_o)) ||
                   (err_cnt_o == $past(err_cnt_o) + 1'b1));

  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_i |=> err_cnt_o == '0);

  p_err_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(err_cnt_o) == '0 && err_cnt_o != '0);
endmodule

bind link_crc_guard link_crc_guard_chk #(.WIDE_W(WIDE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_link_crc_guard.sv
`timescale 1ns/1ps
module tb_link_crc_guard;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wide_i = 1'b0, crc_en_i = 1'b0, clr_err_i = 1'b0;
  logic        tx_valid_i = 1'b0, tx_ready_i = 1'b1;
  logic [29:0] tx_data_i = '0;
  logic        tx_ready_o, tx_valid_o;
  logic [30:0] tx_word_o;
  logic        rx_valid_i = 1'b0, rx_ready_i = 1'b1;
  logic [30:0] rx_word_i = '0;
  logic        rx_ready_o, rx_valid_o, rx_crc_err_o, rx_par_err_o, err_o;
  logic [29:0] rx_data_o;
  logic [7:0]  err_cnt_o;

  int n_chk = 0, n_fail = 0;
  int exp_cnt = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  always #2.5 clk_i = ~clk_i;

  link_crc_guard dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // remainder of p * x^6 modulo x^6 + x + 1
  function automatic logic [5:0] crc_ref(input logic [29:0] p);
    logic [35:0] v = {p, 6'b0};
    for (int i = 35; i >= 6; i--)
      if (v[i]) v = v ^ (36'h43 << (i - 6));
    return v[5:0];
  endfunction

  function automatic logic [30:0] exp_word(input logic [29:0] d, input bit wide, input bit crc);
    int n = crc ? (wide ? 24 : 16) : (wide ? 30 : 22);
    logic [29:0] p = '0, body;
    int ones = 0;
    for (int i = 0; i < n; i++) p[i] = d[i];
    body = crc ? ((p << 6) | {24'b0, crc_ref(p)}) : p;
    for (int i = 0; i < 30; i++) ones += body[i];
    return {body, 1'(ones % 2)};
  endfunction

  task automatic do_tx(input logic [29:0] d, output logic [30:0] w);
    @(negedge clk_i);
    tx_data_i = d; tx_valid_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    w = tx_word_o;
    chk(tx_valid_o === 1'b1, "R10", "tx valid", 64'(tx_valid_o), 64'd1);
    chk(tx_word_o === exp_word(d, wide_i, crc_en_i), crc_en_i ? "R1" : "R2",
        "tx word", 64'(tx_word_o), 64'(exp_word(d, wide_i, crc_en_i)));
  endtask

  task automatic do_rx(input logic [30:0] w, input bit clr);
    int bw = wide_i ? 30 : 22;
    int ones = 0;
    logic [30:0] m = '0;
    logic [29:0] body, ed;
    logic ecrc, epar;
    for (int i = 0; i <= bw; i++) m[i] = w[i];
    for (int i = 0; i <= 30; i++) ones += m[i];
    epar = 1'(ones % 2);
    body = m[30:1];
    if (crc_en_i) begin
      ed = body >> 6;
      ecrc = crc_ref(ed) != body[5:0];
    end else begin
      ed = body; ecrc = 1'b0;
    end
    if (clr) exp_cnt = 0;
    else if ((ecrc || epar) && exp_cnt < 255) exp_cnt++;
    @(negedge clk_i);
    rx_word_i = w; rx_valid_i = 1'b1; clr_err_i = clr;
    @(negedge clk_i);
    rx_valid_i = 1'b0; clr_err_i = 1'b0;
    chk(rx_valid_o === 1'b1, "R10", "rx valid", 64'(rx_valid_o), 64'd1);
    chk(rx_data_o === ed, crc_en_i ? "R4" : "R9", "rx data", 64'(rx_data_o), 64'(ed));
    chk(rx_crc_err_o === ecrc, crc_en_i ? "R4" : "R9", "crc flag", 64'(rx_crc_err_o), 64'(ecrc));
    chk(rx_par_err_o === epar, "R5", "parity flag", 64'(rx_par_err_o), 64'(epar));
    chk(err_cnt_o === 8'(exp_cnt), clr ? "R7" : "R6", "err count", 64'(err_cnt_o), 64'(exp_cnt));
    chk(err_o === (exp_cnt != 0), "R8", "err pin", 64'(err_o), 64'(exp_cnt != 0));
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [30:0] w, wa;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(tx_valid_o === 1'b0 && rx_valid_o === 1'b0, "R11", "valids after reset",
        64'({tx_valid_o, rx_valid_o}), 64'd0);
    chk(err_cnt_o === 8'd0, "R11", "count after reset", 64'(err_cnt_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tx_ready_o === 1'b1 && rx_ready_o === 1'b1, "R10", "ready when empty",
        64'({tx_ready_o, rx_ready_o}), 64'h3);

    // R1 R2 R3 R4 R5: sweep modes, loopback, every single-bit flip
    for (int m = 0; m < 4; m++) begin
      wide_i = m[1]; crc_en_i = m[0];
      for (int k = 0; k < 30; k++) begin
        lfsr = step(lfsr);
        do_tx((k < 6) ? (30'h1 << (k * 5)) : lfsr[29:0], w);
        chk((^w) == 1'b0, "R3", "even word parity", 64'(w), 64'd0);
        do_rx(w, 1'b0);
        if (k == 7)
          for (int b = 0; b < 31; b++) do_rx(w ^ (31'h1 << b), 1'b0);
        if (k == 8) do_rx(w ^ 31'h6, 1'b0);        // R4: double flip inside CRC field
        if (k == 9) do_rx(w | 31'h4000_0000, 1'b0); // R12: upper bit
      end
      do_tx(30'h3FFF_FFFF, w);  // R2: all-ones input, upper bits dropped
    end

    // R9: CRC off, corrupt low body bits with parity kept
    wide_i = 1'b1; crc_en_i = 1'b0;
    do_tx(30'h0123_4567, w);
    do_rx(w ^ 31'h6, 1'b0);

    // R12: narrow mode, bits above 22 set
    wide_i = 1'b0; crc_en_i = 1'b1;
    do_tx(30'h0000_BEEF, w);
    do_rx(w | 31'h7F80_0000, 1'b0);

    // R10 backpressure on the tx side
    tx_ready_i = 1'b0;
    @(negedge clk_i);
    tx_data_i = 30'h0000_1234; tx_valid_i = 1'b1;
    @(negedge clk_i);
    wa = exp_word(30'h0000_1234, 1'b0, 1'b1);
    tx_data_i = 30'h0000_5678;
    chk(tx_ready_o === 1'b0, "R10", "tx ready low when full", 64'(tx_ready_o), 64'd0);
    chk(tx_word_o === wa, "R10", "held word", 64'(tx_word_o), 64'(wa));
    @(negedge clk_i);
    chk(tx_word_o === wa && tx_valid_o === 1'b1, "R10", "word stable", 64'(tx_word_o), 64'(wa));
    tx_ready_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    chk(tx_word_o === exp_word(30'h0000_5678, 1'b0, 1'b1), "R10", "next word",
        64'(tx_word_o), 64'(exp_word(30'h0000_5678, 1'b0, 1'b1)));
    @(negedge clk_i);
    chk(tx_valid_o === 1'b0, "R10", "tx drained", 64'(tx_valid_o), 64'd0);

    // R6 saturation
    wide_i = 1'b0; crc_en_i = 1'b0;
    for (int i = 0; i < 270; i++) do_rx(31'h1, 1'b0);
    chk(err_cnt_o === 8'd255, "R6", "saturated", 64'(err_cnt_o), 64'd255);
    // R7 clear wins over a bad word
    do_rx(31'h1, 1'b1);
    chk(err_cnt_o === 8'd0 && err_o === 1'b0, "R7", "clear priority", 64'(err_cnt_o), 64'd0);
    do_rx(31'h1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule